// File: doc/BRIEF.md
# Bit-Serial Adder with Registered Start

This block adds two small unsigned operands and a carry-in using one full adder and a carry flip-flop, one bit position per clock, least significant bit first. A start request may come from logic that is not timed to the system clock. It is first registered into the clock domain and only then seen by the controller. That register adds one clock of latency.

A two-bit binary step counter paces the addition. Its all-zero code, while the block is idle, is the ready/done condition. Every output comes straight from a flip-flop, so no decode glitch can appear on the outputs while the counter bits change. A finished result stays on the outputs until the next addition completes.

Top module: `bsa_top`

## Requirements
- R1: `start_async` is captured by a clock register before the controller sees it. If it rises between two clock edges, the first edge captures it with `done` still 1. The operands load at the second edge, and `done` reads 0 after that edge.
- R2: While an addition runs, the step counter advances by one per clock in binary order 00, 01, 10, 11 and wraps to 00. The addition takes exactly four add clocks, so the result appears at the fifth edge after the load edge's predecessor. Counted from the load edge, it appears at the fourth edge after it.
- R3: `done` is 1 after reset and while idle. It is 0 from the load edge until the completing edge. It is 1 only while the step counter is 00.
- R4: At completion, `sum_out` equals bits 3..0 of `op_a + op_b + carry_in`, and `carry_out` equals bit 4 of that sum. Operands and carry-in are taken as unsigned.
- R5: `sum_out` and `carry_out` change only at a completing edge. They hold their values through idle time and through the following addition until it completes.
- R6: `done_pulse` is 1 for exactly the one clock after a completing edge, and 0 otherwise.
- R7: A start seen while an addition runs is ignored. Operands are sampled only at the load edge, and no extra addition follows.
- R8: A synchronous active-high `rst` sets the counter to 00, makes `done` 1, and clears `sum_out`, `carry_out` and `done_pulse` to 0. This includes a reset applied during an addition.
- R9: A registered start present at the completing edge is not accepted there. If it is still present at the next edge, that edge loads a new addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_async | input | 1 | Start request, not timed to `clk` |
| op_a | input | 4 | First operand, sampled at the load edge |
| op_b | input | 4 | Second operand, sampled at the load edge |
| carry_in | input | 1 | Carry-in, sampled at the load edge |
| sum_out | output | 4 | Registered sum of the last completed addition |
| carry_out | output | 1 | Registered carry-out of the last completed addition |
| done | output | 1 | Registered idle/done level |
| done_pulse | output | 1 | One-clock pulse after each completion |

## Verification
The completion of one addition and the arrival of the next registered start can fall on the same clock edge. Holding `start_async` high without a break provokes this, because the registered start is still high when the fourth add clock completes. The bench judges the outcome as follows. `done` must read 1 for exactly the one clock after completion, with `done_pulse` set and the first result on the outputs. `done` must then drop at the next edge, and the second result, built from operands changed in between, must appear four clocks later.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  parameter int unsigned BSA_WIDTH = 4;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/bsa_sync.sv
module bsa_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  always_ff @(posedge clk) begin
    if (rst) sync_out <= 1'b0;
    else     sync_out <= async_in;
  end

endmodule

// File: rtl/bsa_fa.sv
module bsa_fa
  import bsa_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  always_comb begin
    s  = x ^ y ^ ci;
    co = maj3(x, y, ci);
  end

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl #(
  parameter int unsigned WIDTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_s,
  output logic                     load,
  output logic                     run,
  output logic [$clog2(WIDTH)-1:0] step,
  output logic                     done,
  output logic                     done_pulse
);

  localparam int unsigned STEP_W = $clog2(WIDTH);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(WIDTH - 1);

  logic finish;

  assign load   = start_s && !run;
  assign finish = run && (step == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      run        <= 1'b0;
      done       <= 1'b1;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= finish;
      if (load) begin
        run  <= 1'b1;
        done <= 1'b0;
      end else if (run) begin
        step <= step + 1'b1;
        if (finish) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath #(
  parameter int unsigned WIDTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     run,
  input  logic [$clog2(WIDTH)-1:0] step,
  input  logic [WIDTH-1:0]         a_in,
  input  logic [WIDTH-1:0]         b_in,
  input  logic                     cin,
  output logic [WIDTH-1:0]         sum_out,
  output logic                     cout
);

  localparam int unsigned STEP_W = $clog2(WIDTH);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(WIDTH - 1);

  logic [WIDTH-1:0] a_sh, b_sh, sum_sh;
  logic             carry_q;
  logic             bit_s, bit_c;
  logic             last;

  assign last = run && (step == LAST);

  bsa_fa i_fa (
    .x  (a_sh[0]),
    .y  (b_sh[0]),
    .ci (carry_q),
    .s  (bit_s),
    .co (bit_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh    <= '0;
      b_sh    <= '0;
      sum_sh  <= '0;
      carry_q <= 1'b0;
      sum_out <= '0;
      cout    <= 1'b0;
    end else if (load) begin
      a_sh    <= a_in;
      b_sh    <= b_in;
      sum_sh  <= '0;
      carry_q <= cin;
    end else if (run) begin
      a_sh    <= a_sh >> 1;
      b_sh    <= b_sh >> 1;
      sum_sh  <= {bit_s, sum_sh[WIDTH-1:1]};
      carry_q <= bit_c;
      if (last) begin
        sum_out <= {bit_s, sum_sh[WIDTH-1:1]};
        cout    <= bit_c;
      end
    end
  end

endmodule

// File: rtl/bsa_top.sv
module bsa_top #(
  parameter int unsigned WIDTH = bsa_pkg::BSA_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_async,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             done,
  output logic             done_pulse
);

  localparam int unsigned STEP_W = $clog2(WIDTH);

  logic              start_s;
  logic              load_w;
  logic              run_w;
  logic [STEP_W-1:0] step_w;

  bsa_sync i_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (start_async),
    .sync_out (start_s)
  );

  bsa_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_s    (start_s),
    .load       (load_w),
    .run        (run_w),
    .step       (step_w),
    .done       (done),
    .done_pulse (done_pulse)
  );

  bsa_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (load_w),
    .run     (run_w),
    .step    (step_w),
    .a_in    (op_a),
    .b_in    (op_b),
    .cin     (carry_in),
    .sum_out (sum_out),
    .cout    (carry_out)
  );

endmodule

// File: rtl/bsa_chk.sv
module bsa_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start_s,
  input logic                     run,
  input logic [$clog2(WIDTH)-1:0] step,
  input logic [WIDTH-1:0]         sum_out,
  input logic                     carry_out,
  input logic                     done,
  input logic                     done_pulse
);

  localparam int unsigned STEP_W = $clog2(WIDTH);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(WIDTH - 1);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r1_load_after_sync: assert property (@(posedge clk) disable iff (rst)
    (start_s && done) |=> (!done && run));

  a_r2_step_advance: assert property (@(posedge clk) disable iff (rst)
    run |=> (step == STEP_W'($past(step) + 1'b1)));

  a_r3_done_at_zero: assert property (@(posedge clk) disable iff (rst)
    done |-> (step == '0));

  a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !done_pulse) |-> ($stable(sum_out) && $stable(carry_out)));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  a_r7_busy_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (run && step != LAST) |=> run);

  a_r9_no_accept_at_finish: assert property (@(posedge clk) disable iff (rst)
    (run && step == LAST) |=> (done && !run));

  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (done && !done_pulse && sum_out == '0 && !carry_out && step == '0));

endmodule

bind bsa_top bsa_chk #(.WIDTH(WIDTH)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .start_s    (start_s),
  .run        (run_w),
  .step       (step_w),
  .sum_out    (sum_out),
  .carry_out  (carry_out),
  .done       (done),
  .done_pulse (done_pulse)
);

// File: tb/test_bsa_top.sv
module test_bsa_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_async = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic       carry_in = 1'b0;
  logic [3:0] sum_out;
  logic       carry_out;
  logic       done;
  logic       done_pulse;

  int checks = 0;
  int errors = 0;
  int prev_sum = 0;
  int prev_c = 0;

  always #4 clk = ~clk;

  bsa_top i_bsa_top (
    .clk         (clk),
    .rst         (rst),
    .start_async (start_async),
    .op_a        (op_a),
    .op_b        (op_b),
    .carry_in    (carry_in),
    .sum_out     (sum_out),
    .carry_out   (carry_out),
    .done        (done),
    .done_pulse  (done_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) tick();
    chk(done == 1'b1, "R8 done after reset", int'(done), 1);
    chk(sum_out == 4'd0, "R8 sum after reset", int'(sum_out), 0);
    chk(carry_out == 1'b0, "R8 carry after reset", int'(carry_out), 0);
    chk(done_pulse == 1'b0, "R8 pulse after reset", int'(done_pulse), 0);
    rst = 1'b0;
    tick();
    chk(done == 1'b1, "R3 done idle", int'(done), 1);
    prev_sum = 0;
    prev_c = 0;
  endtask

  task automatic t_one_add(input int a, input int b, input int c, input int off);
    int tot;
    tot = a + b + c;
    op_a = 4'(a);
    op_b = 4'(b);
    carry_in = 1'(c);
    @(posedge clk);
    #(off);
    start_async = 1'b1;
    tick();
    chk(done == 1'b1, "R1 no load at capture edge", int'(done), 1);
    tick();
    chk(done == 1'b0, "R1 load at second edge", int'(done), 0);
    start_async = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(done == 1'b0 && done_pulse == 1'b0, "R2 still adding", int'(done), 0);
      chk(sum_out == 4'(prev_sum) && carry_out == 1'(prev_c), "R5 hold during add",
          int'(sum_out), prev_sum);
      tick();
    end
    tick();
    chk(done == 1'b1, "R2 completes after four add clocks", int'(done), 1);
    chk(done_pulse == 1'b1, "R6 pulse at completion", int'(done_pulse), 1);
    chk(sum_out == 4'(tot), "R4 sum bits", int'(sum_out), tot % 16);
    chk(carry_out == 1'(tot >> 4), "R4 carry out", int'(carry_out), tot >> 4);
    prev_sum = tot % 16;
    prev_c = tot >> 4;
    tick();
    chk(done_pulse == 1'b0, "R6 pulse one clock", int'(done_pulse), 0);
    chk(done == 1'b1 && sum_out == 4'(prev_sum), "R5 hold while idle", int'(sum_out), prev_sum);
  endtask

  task automatic t_busy_start();
    t_one_add(5, 6, 0, 3);
    op_a = 4'd9; op_b = 4'd7; carry_in = 1'b1;
    @(posedge clk); #2; start_async = 1'b1;
    tick(); tick();
    start_async = 1'b0;
    op_a = 4'd0; op_b = 4'd0; carry_in = 1'b0;
    @(posedge clk); #5; start_async = 1'b1;
    tick();
    start_async = 1'b0;
    tick(); tick();
    chk(done == 1'b1 && done_pulse == 1'b1, "R7 busy start leaves run intact", int'(done), 1);
    chk(sum_out == 4'd1 && carry_out == 1'b1, "R7 operands from load edge", int'(sum_out), 1);
    tick();
    chk(done == 1'b1, "R7 no extra addition", int'(done), 1);
    tick();
    chk(done == 1'b1 && sum_out == 4'd1, "R7 idle after ignored start", int'(sum_out), 1);
    prev_sum = 1; prev_c = 1;
  endtask

  task automatic t_back_to_back();
    op_a = 4'd3; op_b = 4'd4; carry_in = 1'b0;
    @(posedge clk); #6; start_async = 1'b1;
    tick(); tick();
    op_a = 4'd15; op_b = 4'd15; carry_in = 1'b1;
    tick(); tick(); tick(); tick();
    chk(done == 1'b1 && done_pulse == 1'b1, "R9 completion with start pending", int'(done), 1);
    chk(sum_out == 4'd7 && carry_out == 1'b0, "R9 first result", int'(sum_out), 7);
    tick();
    chk(done == 1'b0, "R9 reload on following edge", int'(done), 0);
    chk(done_pulse == 1'b0 && sum_out == 4'd7, "R9 first result held", int'(sum_out), 7);
    start_async = 1'b0;
    tick(); tick(); tick(); tick();
    chk(done == 1'b1 && done_pulse == 1'b1, "R9 second completion", int'(done), 1);
    chk(sum_out == 4'd15 && carry_out == 1'b1, "R9 second result", int'(sum_out), 15);
    tick();
    chk(done == 1'b1, "R9 idle after release", int'(done), 1);
    prev_sum = 15; prev_c = 1;
  endtask

  task automatic t_reset_midrun();
    op_a = 4'd12; op_b = 4'd10; carry_in = 1'b1;
    @(posedge clk); #4; start_async = 1'b1;
    tick(); tick();
    start_async = 1'b0;
    tick();
    rst = 1'b1;
    tick(); tick();
    chk(done == 1'b1 && done_pulse == 1'b0, "R8 reset during add", int'(done), 1);
    chk(sum_out == 4'd0 && carry_out == 1'b0, "R8 result cleared", int'(sum_out), 0);
    rst = 1'b0;
    tick(); tick(); tick(); tick(); tick();
    chk(done == 1'b1 && sum_out == 4'd0, "R8 stays idle after reset", int'(sum_out), 0);
    prev_sum = 0; prev_c = 0;
  endtask

  task automatic t_exhaustive();
    int idx = 0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          t_one_add(a, b, c, 1 + (idx * 3) % 7);
          idx++;
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_one_add(15, 15, 1, 7);
    t_busy_start();
    t_back_to_back();
    t_reset_midrun();
    t_exhaustive();
    finish_run();
  end

endmodule